// File: doc/BRIEF.md
# Echo Path Level Control Stage

This block sits at the end of an echo canceller's voice path and handles one frame of the 8 kHz rate per transaction. Each frame brings one linear receive-side sample and one linear send-side sample. The block returns a mu-law code for each direction.

Three level functions act on the pair, and each has its own control pin:
- **Howling guard.** It takes 6 dB off either the receive signal or the send signal, always exactly one of the two. The choice comes from which paths are currently active.
- **Receive-side compressor.** It pulls loud receive levels down towards a fixed target, with a capped reduction.
- **Send-side center clip.** It replaces a quiet send signal with the mu-law silence code.

A per-path leaky power average supplies both the activity flags and the levels. That average is updated once per accepted frame. All level comparisons are made in the power domain, against thresholds derived from a parameterised 0 dBm0 power reference.

The sample stream enters through a valid/ready pair and leaves through a valid/ready pair. A frame is accepted on a clock edge where `in_valid` and `in_ready` are both high. One result register sits at the output. `in_ready` is high whenever that register is empty, or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output codes hold still and no new frame is taken. The control pins are sampled on the accepting edge.

Top module: `echo_level_ctrl`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted frame sets `out_valid` on the next edge. While `out_valid` is high and `out_ready` is low, `out_valid`, `rx_code` and `tx_code` stay unchanged.
- R2: After reset, `out_valid` is low, both power estimates are zero and both hangover counters are zero. The first frame therefore sees both paths inactive.
- R3: Every decision for a frame uses the power state held before that frame. After the frame, a path's power P becomes P - (P>>4) + ((x*x)>>4). Outputs are mu-law codes formed as follows:
  - m = min(|x|>>2, 8158) + 33, where x is the 16-bit two's-complement sample.
  - seg is the highest i in 0..7 with m >= 32<<i, and mant = (m>>(seg+1)) & 15.
  - The code is {seg,mant} XOR 0xFF for x >= 0, and XOR 0x7F for x < 0.
- R4: A path is active when its power exceeds LEVEL_REF/1000 (-30 dBm0), or when its hangover counter is nonzero. When the receive path is active, the send path is inactive and `att_bypass` is low, the send sample is shifted right arithmetically by one bit (6 dB) and the receive sample is left alone.
- R5: In every other activity state with `att_bypass` low (send active, or both paths idle), the receive sample is shifted right arithmetically by one bit (after the compressor) and the send sample is left alone.
- R6: With `att_bypass` high, neither path is attenuated.
- R7: After each frame, a path's hangover counter loads 6 if its power before the frame exceeded the detection threshold. Otherwise the counter decrements, saturating at zero. This keeps a path active for six frames after its level falls.
- R8: With `gc_en` high, the compressor step count k is the number of thresholds T_j (j = 1..17) that the receive power meets or exceeds. Here T_0 = LEVEL_REF/100 (-20 dBm0) and T_j = floor(T_(j-1)*73533/65536), a step of 0.5 dB. The gain is G_k, with G_0 = 32768 and G_k = floor(G_(k-1)*61870/65536). The receive sample becomes (x*G_k)>>>15.
- R9: Receive power at or above T_17 (about -11.5 dBm0) always gets the maximum reduction of 8.5 dB, gain G_17.
- R10: With `clip_en` high and the send power below LEVEL_REF/251189 (about -54 dBm0), `tx_code` is 0xFF, whatever the send sample or the attenuator.
- R11: With `gc_en` low, the receive sample passes the compressor at unity gain for any level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A frame is offered |
| in_ready | output | 1 | Block can take a frame this cycle |
| rx_sample | input | 16 | Linear receive sample, two's complement |
| tx_sample | input | 16 | Linear send sample, two's complement |
| att_bypass | input | 1 | High turns the howling attenuator off; low turns it on |
| gc_en | input | 1 | Receive compressor enable |
| clip_en | input | 1 | Send center clip enable |
| out_valid | output | 1 | Result register holds a frame |
| out_ready | input | 1 | Consumer takes the result this cycle |
| rx_code | output | 8 | Mu-law receive output |
| tx_code | output | 8 | Mu-law send output |

## Verification
Several behaviours depend on a leaky power average that moves slowly from frame to frame. Only frame history can place that average just past a compressor step, or hold it inside the six-frame hangover window. The stimulus therefore ramps the receive amplitude slowly across the whole compressor range, and drops a loud receive path to silence while a faint send signal keeps the attenuator choice visible in the codes. A behavioural model tracks the exact integer power of both paths, so every frame's expected codes are known even at a step edge. Back-pressure is exercised with an irregular `out_ready` pattern while frames are offered back to back.

// File: rtl/elc_pkg.sv
package elc_pkg;

  // power ratio of one 0.5 dB step, Q16
  localparam longint unsigned STEP_POW_Q16 = 64'd73533;
  // amplitude ratio of one 0.5 dB reduction, Q16
  localparam longint unsigned STEP_AMP_Q16 = 64'd61870;
  localparam int unsigned UNITY_GAIN = 32768;

  typedef enum int {PATH_RX = 0, PATH_TX = 1} path_e;

  // threshold j steps above the knee, computed by repeated integer scaling
  function automatic longint unsigned step_threshold(longint unsigned knee, int j);
    longint unsigned t;
    t = knee;
    for (int i = 0; i < j; i++) t = (t * STEP_POW_Q16) >> 16;
    return t;
  endfunction

  // Q15 gain for k reduction steps
  function automatic logic [15:0] step_gain(int k);
    longint unsigned g;
    g = 64'(UNITY_GAIN);
    for (int i = 0; i < k; i++) g = (g * STEP_AMP_Q16) >> 16;
    return 16'(g);
  endfunction

endpackage

// File: rtl/elc_power_track.sv
module elc_power_track #(
  parameter int W = 16,
  parameter int AVG_SHIFT = 4,
  parameter longint unsigned DET_POW = 64'd257000,
  parameter int HANG = 6,
  localparam int POW_W = 2 * W,
  localparam int HANG_W = $clog2(HANG + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                update,
  input  logic signed [W-1:0] sample,
  output logic [POW_W-1:0]    pow,
  output logic [HANG_W-1:0]   hang,
  output logic                active
);
  localparam logic [POW_W-1:0] DET_L = POW_W'(DET_POW);
  localparam logic [HANG_W-1:0] HANG_L = HANG_W'(HANG);

  logic signed [POW_W-1:0] prod;
  logic [POW_W-1:0] sq;
  logic [POW_W-1:0] pow_next;
  logic [HANG_W-1:0] hang_next;
  logic loud;

  always_comb begin
    prod = sample * sample;
    sq = $unsigned(prod);
    pow_next = pow - (pow >> AVG_SHIFT) + (sq >> AVG_SHIFT);
    loud = pow > DET_L;
    if (loud) hang_next = HANG_L;
    else if (hang != '0) hang_next = hang - 1'b1;
    else hang_next = '0;
    active = loud || (hang != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pow <= '0;
      hang <= '0;
    end else if (update) begin
      pow <= pow_next;
      hang <= hang_next;
    end
  end
endmodule

// File: rtl/elc_compressor.sv
module elc_compressor
  import elc_pkg::*;
#(
  parameter int W = 16,
  parameter int POW_W = 32,
  parameter longint unsigned KNEE_POW = 64'd2570000,
  parameter int STEPS = 17,
  localparam int SW = $clog2(STEPS + 1)
) (
  input  logic                en,
  input  logic [POW_W-1:0]    pow,
  input  logic signed [W-1:0] sample,
  output logic signed [W-1:0] scaled,
  output logic [15:0]         gain
);
  logic [STEPS-1:0] above;
  logic [15:0] gain_tab [STEPS+1];
  logic [SW-1:0] idx;
  logic signed [W+16:0] prod;

  for (genvar j = 1; j <= STEPS; j++) begin : g_thr
    localparam logic [POW_W-1:0] TH = POW_W'(step_threshold(KNEE_POW, j));
    assign above[j-1] = pow >= TH;
  end

  for (genvar k = 0; k <= STEPS; k++) begin : g_gain
    assign gain_tab[k] = step_gain(k);
  end

  always_comb begin
    idx = '0;
    for (int j = 0; j < STEPS; j++) idx = idx + SW'(above[j]);
    gain = en ? gain_tab[idx] : 16'(UNITY_GAIN);
    prod = sample * $signed({1'b0, gain});
    scaled = W'(prod >>> 15);
  end
endmodule

// File: rtl/elc_mulaw_enc.sv
module elc_mulaw_enc #(
  parameter int W = 16,
  localparam int SHIFT = W - 14
) (
  input  logic signed [W-1:0] sample,
  input  logic                silence,
  output logic [7:0]          code
);
  logic neg;
  logic [W:0] mag_full;
  logic [W:0] mag_sh;
  logic [12:0] mag;
  logic [2:0] seg;
  logic [12:0] mant_full;

  always_comb begin
    neg = sample[W-1];
    mag_full = neg ? -{sample[W-1], sample} : {1'b0, sample};
    mag_sh = mag_full >> SHIFT;
    mag = (mag_sh > (W+1)'(8158)) ? 13'd8191 : 13'(mag_sh) + 13'd33;
    seg = '0;
    for (int i = 0; i < 8; i++) if (mag[i+5]) seg = 3'(i);
    mant_full = mag >> (int'(seg) + 1);
    code = {1'b0, seg, mant_full[3:0]} ^ (neg ? 8'h7F : 8'hFF);
    if (silence) code = 8'hFF;
  end
endmodule

// File: rtl/echo_level_ctrl.sv
module echo_level_ctrl
  import elc_pkg::*;
#(
  parameter int W = 16,
  parameter int AVG_SHIFT = 4,
  parameter longint unsigned LEVEL_REF = 64'd257000000,
  parameter longint unsigned DET_DIV = 64'd1000,
  parameter longint unsigned KNEE_DIV = 64'd100,
  parameter longint unsigned CLIP_DIV = 64'd251189,
  parameter int HANG = 6,
  parameter int STEPS = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] rx_sample,
  input  logic [W-1:0] tx_sample,
  input  logic         att_bypass,
  input  logic         gc_en,
  input  logic         clip_en,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [7:0]   rx_code,
  output logic [7:0]   tx_code
);
  localparam int POW_W = 2 * W;
  localparam int HANG_W = $clog2(HANG + 1);
  localparam longint unsigned DET_POW = LEVEL_REF / DET_DIV;
  localparam longint unsigned KNEE_POW = LEVEL_REF / KNEE_DIV;
  localparam longint unsigned CLIP_POW = LEVEL_REF / CLIP_DIV;
  localparam logic [POW_W-1:0] CLIP_L = POW_W'(CLIP_POW);
  localparam int NPATH = 2;

  logic accept;
  logic signed [W-1:0] path_sample [NPATH];
  logic [POW_W-1:0] path_pow [NPATH];
  logic [HANG_W-1:0] path_hang [NPATH];
  logic path_active [NPATH];

  logic rx_only, att_rx, att_tx, quiet_tx;
  logic signed [W-1:0] rx_comp, rx_lin, tx_lin;
  logic [15:0] rx_gain;
  logic [7:0] rx_enc, tx_enc;

  assign in_ready = !out_valid || out_ready;
  assign accept = in_valid && in_ready;
  assign path_sample[PATH_RX] = $signed(rx_sample);
  assign path_sample[PATH_TX] = $signed(tx_sample);

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    elc_power_track #(
      .W(W), .AVG_SHIFT(AVG_SHIFT), .DET_POW(DET_POW), .HANG(HANG)
    ) u_track (
      .clk(clk), .rst_n(rst_n), .update(accept),
      .sample(path_sample[p]), .pow(path_pow[p]),
      .hang(path_hang[p]), .active(path_active[p])
    );
  end

  elc_compressor #(
    .W(W), .POW_W(POW_W), .KNEE_POW(KNEE_POW), .STEPS(STEPS)
  ) u_comp (
    .en(gc_en), .pow(path_pow[PATH_RX]), .sample(path_sample[PATH_RX]),
    .scaled(rx_comp), .gain(rx_gain)
  );

  always_comb begin
    rx_only = path_active[PATH_RX] && !path_active[PATH_TX];
    att_tx = !att_bypass && rx_only;
    att_rx = !att_bypass && !rx_only;
    rx_lin = att_rx ? (rx_comp >>> 1) : rx_comp;
    tx_lin = att_tx ? (path_sample[PATH_TX] >>> 1) : path_sample[PATH_TX];
    quiet_tx = clip_en && (path_pow[PATH_TX] < CLIP_L);
  end

  elc_mulaw_enc #(.W(W)) u_enc_rx (.sample(rx_lin), .silence(1'b0), .code(rx_enc));
  elc_mulaw_enc #(.W(W)) u_enc_tx (.sample(tx_lin), .silence(quiet_tx), .code(tx_enc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rx_code <= 8'hFF;
      tx_code <= 8'hFF;
    end else if (accept) begin
      out_valid <= 1'b1;
      rx_code <= rx_enc;
      tx_code <= tx_enc;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/elc_checker.sv
module elc_checker #(
  parameter int POW_W = 32,
  parameter int HANG_W = 3,
  parameter int HANG = 6,
  parameter longint unsigned DET_POW = 64'd257000,
  parameter longint unsigned CLIP_POW = 64'd1023
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        rx_code,
  input logic [7:0]        tx_code,
  input logic              gc_en,
  input logic              clip_en,
  input logic [POW_W-1:0]  rx_pow,
  input logic [POW_W-1:0]  tx_pow,
  input logic [HANG_W-1:0] rx_hang,
  input logic [15:0]       rx_gain
);
  localparam logic [POW_W-1:0] DET_L = POW_W'(DET_POW);
  localparam logic [POW_W-1:0] CLIP_L = POW_W'(CLIP_POW);
  localparam logic [HANG_W-1:0] HANG_L = HANG_W'(HANG);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(rx_code) && $stable(tx_code));

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_pow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(rx_pow) && $stable(tx_pow));

  assert_hang_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (rx_pow > DET_L) |=> rx_hang == HANG_L);

  assert_silence_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && clip_en && (tx_pow < CLIP_L) |=> tx_code == 8'hFF);

  assert_unity_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !gc_en |-> rx_gain == 16'h8000);
endmodule

bind echo_level_ctrl elc_checker #(
  .POW_W(POW_W), .HANG_W(HANG_W), .HANG(HANG),
  .DET_POW(DET_POW), .CLIP_POW(CLIP_POW)
) u_elc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .rx_code(rx_code),
  .tx_code(tx_code), .gc_en(gc_en), .clip_en(clip_en),
  .rx_pow(path_pow[0]), .tx_pow(path_pow[1]), .rx_hang(path_hang[0]),
  .rx_gain(rx_gain)
);

// File: tb/echo_level_ctrl_test.sv
`timescale 1ns/1ps
module echo_level_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] rx_sample = '0;
  logic signed [15:0] tx_sample = '0;
  logic att_bypass = 1'b1;
  logic gc_en = 1'b0;
  logic clip_en = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] rx_code, tx_code;

  int errors = 0;
  int checks = 0;
  string cur_req = "R2";
  bit bp_mode = 1'b0;
  bit done = 1'b0;

  localparam longint DET = 257000;
  localparam longint KNEE = 2570000;
  localparam longint CLIPP = 1023;
  localparam int HANGN = 6;

  always #4 clk = ~clk;

  echo_level_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rx_sample(rx_sample), .tx_sample(tx_sample), .att_bypass(att_bypass),
    .gc_en(gc_en), .clip_en(clip_en), .out_valid(out_valid),
    .out_ready(out_ready), .rx_code(rx_code), .tx_code(tx_code)
  );

  // reference model state
  longint m_pow [2];
  int m_hang [2];
  bit m_valid;
  logic [7:0] m_rx, m_tx;

  function automatic logic [7:0] ref_mulaw(int s);
    int m, seg, mant, c;
    m = (s < 0) ? -s : s;
    m = m >> 2;
    if (m > 8158) m = 8158;
    m = m + 33;
    seg = 0;
    for (int i = 0; i < 8; i++) if (m >= (32 << i)) seg = i;
    mant = (m >> (seg + 1)) & 15;
    c = (seg << 4) | mant;
    return (s < 0) ? 8'(c ^ 'h7F) : 8'(c ^ 'hFF);
  endfunction

  function automatic longint ref_thr(int j);
    longint t;
    t = KNEE;
    for (int i = 0; i < j; i++) t = (t * 73533) >>> 16;
    return t;
  endfunction

  function automatic int ref_gain(int k);
    longint g;
    g = 32768;
    for (int i = 0; i < k; i++) g = (g * 61870) >>> 16;
    return int'(g);
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // per-clock comparison and model advance
  always @(negedge clk) begin
    if (!rst_n) begin
      m_pow[0] = 0; m_pow[1] = 0; m_hang[0] = 0; m_hang[1] = 0;
      m_valid = 0; m_rx = 8'hFF; m_tx = 8'hFF;
    end else if (!done) begin
      bit exp_ready, acc;
      check(out_valid == m_valid, "out_valid", int'(out_valid), int'(m_valid));
      exp_ready = !m_valid || out_ready;
      check(in_ready == exp_ready, "in_ready", int'(in_ready), int'(exp_ready));
      if (m_valid) begin
        check(rx_code == m_rx, "rx_code", int'(rx_code), int'(m_rx));
        check(tx_code == m_tx, "tx_code", int'(tx_code), int'(m_tx));
      end
      acc = in_valid && exp_ready;
      if (acc) begin
        bit act_r, act_t, rxonly;
        int k, g, y, z, xr, xt;
        xr = int'(rx_sample);
        xt = int'(tx_sample);
        act_r = (m_pow[0] > DET) || (m_hang[0] != 0);
        act_t = (m_pow[1] > DET) || (m_hang[1] != 0);
        rxonly = act_r && !act_t;
        k = 0;
        if (gc_en) for (int j = 1; j <= 17; j++) if (m_pow[0] >= ref_thr(j)) k++;
        g = ref_gain(k);
        y = (xr * g) >>> 15;
        z = xt;
        if (!att_bypass && !rxonly) y = y >>> 1;
        if (!att_bypass && rxonly) z = z >>> 1;
        m_rx = ref_mulaw(y);
        m_tx = (clip_en && m_pow[1] < CLIPP) ? 8'hFF : ref_mulaw(z);
        m_valid = 1;
        for (int p = 0; p < 2; p++) begin
          longint x, sq;
          x = (p == 0) ? longint'(xr) : longint'(xt);
          sq = x * x;
          if (m_pow[p] > DET) m_hang[p] = HANGN;
          else if (m_hang[p] > 0) m_hang[p]--;
          m_pow[p] = m_pow[p] - (m_pow[p] >>> 4) + (sq >>> 4);
        end
      end else if (m_valid && out_ready) begin
        m_valid = 0;
      end
    end
  end

  // consumer side: irregular back-pressure when requested
  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      out_ready = bp_mode ? ((cyc % 3) != 1 && (cyc % 7) != 2) : 1'b1;
    end
  end

  task automatic send(input int r, input int t);
    in_valid = 1'b1;
    rx_sample = 16'(r);
    tx_sample = 16'(t);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic burst(input int n, input int ra, input int ta);
    for (int i = 0; i < n; i++) send((i % 2) ? ra : -ra, (i % 2) ? -ta : ta);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R2";
    check(out_valid == 1'b0, "reset out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "reset in_ready", int'(in_ready), 1);
    @(posedge clk); #1;
    // R2: first frame sees idle paths, so receive is attenuated
    att_bypass = 1'b0;
    send(1000, 40);
    send(-1000, 40);

    // R3: plain coding, attenuator off, assorted values
    cur_req = "R3";
    att_bypass = 1'b1;
    send(0, 0); send(-1, 1); send(32767, -32768); send(-32768, 32767);
    send(5, -5); send(131, -4000); send(8000, 12345);
    for (int i = 0; i < 40; i++) send(i * 811 - 16000, 15000 - i * 733);

    // R4: receive only active -> send attenuated
    cur_req = "R4";
    att_bypass = 1'b0;
    burst(60, 1000, 20);

    // R7: receive falls silent, hangover keeps the choice for six frames
    cur_req = "R7";
    burst(40, 0, 20);

    // R5: both active, then both idle -> receive attenuated
    cur_req = "R5";
    burst(50, 1000, 1000);
    burst(60, 100, 0);

    // R6: attenuator off with receive-only activity
    cur_req = "R6";
    att_bypass = 1'b1;
    burst(60, 1000, 20);

    // R8: compressor across its step range
    cur_req = "R8";
    gc_en = 1'b1;
    for (int i = 0; i < 120; i++) send((i % 2) ? 1500 + 25 * i : -(1500 + 25 * i), 0);

    // R9: well above the top step
    cur_req = "R9";
    burst(50, 10000, 0);

    // R11: compressor off at the same level
    cur_req = "R11";
    gc_en = 1'b0;
    burst(30, 10000, 0);

    // R10: center clip on a faint send signal, then a loud one
    cur_req = "R10";
    clip_en = 1'b1;
    burst(60, 0, 20);
    burst(30, 0, 2000);
    burst(40, 0, 0);

    // R1: irregular back-pressure with frames offered back to back
    cur_req = "R1";
    bp_mode = 1'b1;
    gc_en = 1'b1;
    att_bypass = 1'b0;
    for (int i = 0; i < 80; i++) send(i * 97 - 3000, 2000 - i * 53);
    bp_mode = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    finish_run();
  end
endmodule